// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit sits in the decode stage of a five-stage load/store pipeline. In the same cycle that the instruction word reaches decode, it pulls the register specifiers and the immediate out of fixed bit positions. It sign-extends the immediate and classifies the instruction for the downstream control logic. For a conditional branch, it compares the two source operands and forms the branch target from the already-incremented fetch address. Each operand is either the register-file read or a forwarded result, as chosen by a select input that external forwarding logic drives.

A taken branch raises a PC-select and a fetch-flush request together, for exactly one cycle. A small two-state machine then remembers that the instruction arriving next in decode is the wrong-path one. The states are `S_RUN` (normal decode) and `S_SQUASH` (the slot after a redirect is being discarded). The machine moves from `S_RUN` to `S_SQUASH` on a redirect. It stays in `S_SQUASH` while the stall input holds the discarded slot in place, and it returns to `S_RUN` on the first cycle without stall. A high stall input blocks any redirect.

Top module: `bru_decode_resolve`

## Requirements
- R1: `src_a_addr_o` always equals instruction bits [25:21] and `src_b_addr_o` bits [20:16], whatever the opcode (opcode is bits [31:26]).
- R2: `imm_ext_o` is instruction bits [15:0] sign-extended to 32 bits, combinationally.
- R3: `target_o` equals `pc_inc_i` plus the sign-extended immediate shifted left by 2, modulo 2^32.
- R4: Opcode 0x04 makes the branch condition true when the operands are equal; opcode 0x05 makes it true when they differ. `taken_o` is the condition while `id_valid_i` is high and the state is `S_RUN`.
- R5: Any opcode other than 0x04 or 0x05, or `id_valid_i` low, never asserts `taken_o`.
- R6: With `fwd_sel_a_i`/`fwd_sel_b_i` high, the compare uses `fwd_a_i`/`fwd_b_i`; when low, it uses `rf_a_i`/`rf_b_i`.
- R7: When `taken_o` is high and `stall_i` is low, `pc_sel_o` and `flush_o` are both high in that same cycle and low in the following one.
- R8: While `stall_i` is high, `pc_sel_o` and `flush_o` stay low, even when the branch condition holds.
- R9: From the cycle after a redirect, `kill_o` is high and `taken_o`, `pc_sel_o` and `flush_o` are held low. This lasts until the end of the first cycle with `stall_i` low; `kill_o` is low in the cycle after that.
- R10: `class_o` codes: 3 for opcode 0x00 (register-register ALU), 1 for 0x23 (load), 2 for 0x2B (store), 4 for 0x08 to 0x0F (register-immediate ALU), 5 for 0x04/0x05 (branch), and 0 (invalid) for every other opcode.
- R11: After reset, the state is `S_RUN` and `kill_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| stall_i | input | 1 | Decode stage is held this cycle |
| instr_i | input | 32 | Instruction word in decode |
| pc_inc_i | input | 32 | Fetch address of the instruction plus 4 |
| rf_a_i | input | 32 | Register-file read for the first source |
| rf_b_i | input | 32 | Register-file read for the second source |
| fwd_a_i | input | 32 | Forwarded value for the first source |
| fwd_b_i | input | 32 | Forwarded value for the second source |
| fwd_sel_a_i | input | 1 | Use the forwarded value for the first source |
| fwd_sel_b_i | input | 1 | Use the forwarded value for the second source |
| src_a_addr_o | output | 5 | First source register specifier |
| src_b_addr_o | output | 5 | Second source register specifier |
| imm_ext_o | output | 32 | Sign-extended immediate |
| class_o | output | 3 | Instruction class code |
| taken_o | output | 1 | Branch condition holds for a live slot |
| target_o | output | 32 | Branch target address |
| pc_sel_o | output | 1 | Steer fetch to `target_o` |
| flush_o | output | 1 | Squash the instruction in fetch |
| kill_o | output | 1 | Current decode slot is wrong-path |

## Verification
Fields, immediate, class, target, taken, PC-select and flush are all due in the same cycle as the inputs that produce them. The only delayed result is `kill_o`, which reflects redirects and stalls from earlier cycles, one clock edge later. The driver applies inputs just after a falling edge and pushes the expected values, including its own squash flag advanced once per call. The monitor compares them two nanoseconds later, before the next rising edge, so every check sees settled combinational outputs and a state register that has been updated once per cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN      = 32;
    localparam int OPC_W     = 6;
    localparam int REG_AW    = 5;
    localparam int IMM_W     = 16;
    localparam int OFF_SHIFT = 2;

    localparam logic [OPC_W-1:0] OP_ALU_RR = 6'h00;
    localparam logic [OPC_W-1:0] OP_BR_EQ  = 6'h04;
    localparam logic [OPC_W-1:0] OP_BR_NE  = 6'h05;
    localparam logic [OPC_W-1:0] OP_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE  = 6'h2B;
    localparam logic [2:0]       OP_RI_HI  = 3'b001;

    typedef enum logic [2:0] {
        CLS_INVALID = 3'd0,
        CLS_LOAD    = 3'd1,
        CLS_STORE   = 3'd2,
        CLS_ALU_RR  = 3'd3,
        CLS_ALU_RI  = 3'd4,
        CLS_BRANCH  = 3'd5
    } instr_class_e;

    typedef enum logic {
        S_RUN    = 1'b0,
        S_SQUASH = 1'b1
    } slot_state_e;

    function automatic instr_class_e classify(input logic [OPC_W-1:0] op);
        instr_class_e c;
        c = CLS_INVALID;
        if (op[OPC_W-1:OPC_W-3] == OP_RI_HI) begin
            c = CLS_ALU_RI;
        end else begin
            unique case (op)
                OP_ALU_RR:          c = CLS_ALU_RR;
                OP_LOAD:            c = CLS_LOAD;
                OP_STORE:           c = CLS_STORE;
                OP_BR_EQ, OP_BR_NE: c = CLS_BRANCH;
                default:            c = CLS_INVALID;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/bru_field_decode.sv
module bru_field_decode
    import bru_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]      instr,
    output logic [OPC_W-1:0]  opcode,
    output logic [REG_AW-1:0] src_a,
    output logic [REG_AW-1:0] src_b,
    output logic [IMM_W-1:0]  imm,
    output instr_class_e      cls
);
    localparam int OPC_LO = W - OPC_W;
    localparam int SA_LO  = OPC_LO - REG_AW;
    localparam int SB_LO  = SA_LO - REG_AW;

    always_comb begin
        opcode = instr[W-1:OPC_LO];
        src_a  = instr[OPC_LO-1:SA_LO];
        src_b  = instr[SA_LO-1:SB_LO];
        imm    = instr[IMM_W-1:0];
        cls    = classify(opcode);
    end

    logic unused_mid;
    assign unused_mid = ^instr[SB_LO-1:IMM_W];
endmodule

// File: rtl/bru_compare.sv
module bru_compare
    import bru_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     rf_val   [2],
    input  logic [W-1:0]     fwd_val  [2],
    input  logic [1:0]       fwd_sel,
    output logic             cond
);
    logic [W-1:0] opnd [2];

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        assign opnd[g] = fwd_sel[g] ? fwd_val[g] : rf_val[g];
    end

    logic same;
    assign same = (opnd[0] == opnd[1]);

    always_comb begin
        unique case (opcode)
            OP_BR_EQ: cond = same;
            OP_BR_NE: cond = !same;
            default:  cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IW    = IMM_W,
    parameter int SHIFT = OFF_SHIFT
) (
    input  logic [IW-1:0] imm,
    input  logic [W-1:0]  pc_inc,
    output logic [W-1:0]  imm_ext,
    output logic [W-1:0]  target
);
    localparam int EXT = W - IW;

    assign imm_ext = {{EXT{imm[IW-1]}}, imm};
    assign target  = pc_inc + (imm_ext << SHIFT);
endmodule

// File: rtl/bru_decode_resolve.sv
module bru_decode_resolve
    import bru_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid_i,
    input  logic              stall_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   pc_inc_i,
    input  logic [XLEN-1:0]   rf_a_i,
    input  logic [XLEN-1:0]   rf_b_i,
    input  logic [XLEN-1:0]   fwd_a_i,
    input  logic [XLEN-1:0]   fwd_b_i,
    input  logic              fwd_sel_a_i,
    input  logic              fwd_sel_b_i,
    output logic [REG_AW-1:0] src_a_addr_o,
    output logic [REG_AW-1:0] src_b_addr_o,
    output logic [XLEN-1:0]   imm_ext_o,
    output logic [2:0]        class_o,
    output logic              taken_o,
    output logic [XLEN-1:0]   target_o,
    output logic              pc_sel_o,
    output logic              flush_o,
    output logic              kill_o
);
    logic [OPC_W-1:0] opcode;
    logic [IMM_W-1:0] imm;
    instr_class_e     cls;
    logic             cond;

    // R1, R10: fixed-position fields and class
    bru_field_decode #(.W(XLEN)) u_fields (
        .instr  (instr_i),
        .opcode (opcode),
        .src_a  (src_a_addr_o),
        .src_b  (src_b_addr_o),
        .imm    (imm),
        .cls    (cls)
    );

    // R4, R6: operand select and compare
    logic [XLEN-1:0] rf_pair  [2];
    logic [XLEN-1:0] fwd_pair [2];
    assign rf_pair[0]  = rf_a_i;
    assign rf_pair[1]  = rf_b_i;
    assign fwd_pair[0] = fwd_a_i;
    assign fwd_pair[1] = fwd_b_i;

    bru_compare #(.W(XLEN)) u_cmp (
        .opcode  (opcode),
        .rf_val  (rf_pair),
        .fwd_val (fwd_pair),
        .fwd_sel ({fwd_sel_b_i, fwd_sel_a_i}),
        .cond    (cond)
    );

    // R2, R3: immediate and target
    bru_target #(.W(XLEN), .IW(IMM_W), .SHIFT(OFF_SHIFT)) u_tgt (
        .imm     (imm),
        .pc_inc  (pc_inc_i),
        .imm_ext (imm_ext_o),
        .target  (target_o)
    );

    assign class_o = cls;

    // Slot state machine (R7, R8, R9, R11)
    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        taken_o  = 1'b0;
        pc_sel_o = 1'b0;
        flush_o  = 1'b0;
        kill_o   = 1'b0;
        unique case (state_q)
            S_RUN: begin
                taken_o = id_valid_i && cond;
                if (taken_o && !stall_i) begin
                    pc_sel_o = 1'b1;
                    flush_o  = 1'b1;
                    state_d  = S_SQUASH;
                end
            end
            S_SQUASH: begin
                kill_o = 1'b1;
                if (!stall_i) state_d = S_RUN;
            end
            default: state_d = S_RUN;
        endcase
    end
endmodule

// File: rtl/bru_checker.sv
module bru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        stall_i,
    input logic        id_valid_i,
    input logic [31:0] instr_i,
    input logic [4:0]  src_a_addr_o,
    input logic [4:0]  src_b_addr_o,
    input logic [2:0]  class_o,
    input logic        taken_o,
    input logic        pc_sel_o,
    input logic        flush_o,
    input logic        kill_o
);
    a_r1_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_addr_o == instr_i[25:21]) && (src_b_addr_o == instr_i[20:16]));

    a_r5_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (class_o != 3'd5 || !id_valid_i) |-> !taken_o);

    a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o && !pc_sel_o);

    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !pc_sel_o && !flush_o);

    a_r9_kill_follows: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> kill_o);

    a_r9_kill_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_o && stall_i) |=> kill_o);

    a_r9_kill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> !taken_o && !pc_sel_o);
endmodule

bind bru_decode_resolve bru_checker u_chk (.*);

// File: tb/sim_bru_decode_resolve.sv
module sim_bru_decode_resolve;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid_i = 1'b0, stall_i = 1'b0;
    logic [31:0] instr_i = '0, pc_inc_i = '0;
    logic [31:0] rf_a_i = '0, rf_b_i = '0, fwd_a_i = '0, fwd_b_i = '0;
    logic        fwd_sel_a_i = 1'b0, fwd_sel_b_i = 1'b0;
    logic [4:0]  src_a_addr_o, src_b_addr_o;
    logic [31:0] imm_ext_o, target_o;
    logic [2:0]  class_o;
    logic        taken_o, pc_sel_o, flush_o, kill_o;

    always #4 clk = ~clk;

    bru_decode_resolve u0 (.*);

    typedef struct {
        string       req;
        logic [4:0]  sa, sb;
        logic [31:0] imm, tgt;
        logic [2:0]  cls;
        logic        tk, ps, fl, kl;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    bit exp_sq = 1'b0;
    bit done = 1'b0;

    function automatic logic [2:0] ref_class(input logic [5:0] op);
        if (op == 6'h00) return 3'd3;
        if (op == 6'h23) return 3'd1;
        if (op == 6'h2B) return 3'd2;
        if (op >= 6'h08 && op <= 6'h0F) return 3'd4;
        if (op == 6'h04 || op == 6'h05) return 3'd5;
        return 3'd0;
    endfunction

    task automatic drive(input string req, input logic v, input logic st,
                         input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] ra, input logic [31:0] rb,
                         input logic [31:0] fa, input logic [31:0] fb,
                         input logic sla, input logic slb);
        exp_t e;
        logic [31:0] a, b;
        logic cnd;
        @(negedge clk);
        id_valid_i = v; stall_i = st; instr_i = ins; pc_inc_i = pc;
        rf_a_i = ra; rf_b_i = rb; fwd_a_i = fa; fwd_b_i = fb;
        fwd_sel_a_i = sla; fwd_sel_b_i = slb;
        a = sla ? fa : ra;
        b = slb ? fb : rb;
        cnd = (ins[31:26] == 6'h04) ? (a == b) :
              (ins[31:26] == 6'h05) ? (a != b) : 1'b0;
        e.req = req;
        e.sa  = ins[25:21];
        e.sb  = ins[20:16];
        e.imm = {{16{ins[15]}}, ins[15:0]};
        e.tgt = pc + {e.imm[29:0], 2'b00};
        e.cls = ref_class(ins[31:26]);
        e.kl  = exp_sq;
        e.tk  = v && !exp_sq && cnd;
        e.ps  = e.tk && !st;
        e.fl  = e.ps;
        q.push_back(e);
        if (!rst_n)      exp_sq = 1'b0;
        else if (e.ps)   exp_sq = 1'b1;
        else if (!st)    exp_sq = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (src_a_addr_o !== e.sa || src_b_addr_o !== e.sb || imm_ext_o !== e.imm ||
                    target_o !== e.tgt || class_o !== e.cls || taken_o !== e.tk ||
                    pc_sel_o !== e.ps || flush_o !== e.fl || kill_o !== e.kl) begin
                    fails++;
                    $display("FAIL %s got sa=%0d sb=%0d imm=%h tgt=%h cls=%0d tk=%b ps=%b fl=%b kl=%b exp sa=%0d sb=%0d imm=%h tgt=%h cls=%0d tk=%b ps=%b fl=%b kl=%b",
                        e.req, src_a_addr_o, src_b_addr_o, imm_ext_o, target_o, class_o,
                        taken_o, pc_sel_o, flush_o, kill_o,
                        e.sa, e.sb, e.imm, e.tgt, e.cls, e.tk, e.ps, e.fl, e.kl);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [31:0] PC0 = 32'h0000_1000;

    initial begin : stimulus
        // R11: reset state, no kill
        drive("R11", 1'b0, 1'b0, 32'h0000_0000, PC0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        drive("R11", 1'b0, 1'b0, 32'h0000_0000, PC0, 0, 0, 0, 0, 0, 0);
        // R1 R10: register-register ALU, fields at fixed bits
        drive("R1", 1'b1, 1'b0, {6'h00, 5'd17, 5'd9, 16'h1234}, PC0, 1, 2, 0, 0, 0, 0);
        // R2 R10: load with negative immediate
        drive("R2", 1'b1, 1'b0, {6'h23, 5'd3, 5'd30, 16'hFFF8}, PC0, 5, 5, 0, 0, 0, 0);
        // R10: store, RI edges, invalid
        drive("R10", 1'b1, 1'b0, {6'h2B, 5'd31, 5'd0, 16'h0010}, PC0, 0, 0, 0, 0, 0, 0);
        drive("R10", 1'b1, 1'b0, {6'h08, 5'd1, 5'd2, 16'h7FFF}, PC0, 0, 0, 0, 0, 0, 0);
        drive("R10", 1'b1, 1'b0, {6'h0F, 5'd1, 5'd2, 16'h8000}, PC0, 0, 0, 0, 0, 0, 0);
        // R5: invalid opcode with equal operands, never taken
        drive("R5", 1'b1, 1'b0, {6'h3F, 5'd4, 5'd4, 16'h0001}, PC0, 7, 7, 0, 0, 0, 0);
        // R5: equal branch but slot not valid
        drive("R5", 1'b0, 1'b0, {6'h04, 5'd4, 5'd4, 16'h0001}, PC0, 7, 7, 0, 0, 0, 0);
        // R4: BNE with equal operands not taken
        drive("R4", 1'b1, 1'b0, {6'h05, 5'd4, 5'd5, 16'h0002}, PC0, 9, 9, 0, 0, 0, 0);
        // R8: equal branch under stall, taken but no redirect
        drive("R8", 1'b1, 1'b1, {6'h04, 5'd4, 5'd5, 16'h0003}, PC0, 9, 9, 0, 0, 0, 0);
        // R7 R3: BEQ taken, redirect with backward target
        drive("R7", 1'b1, 1'b0, {6'h04, 5'd4, 5'd5, 16'hFFFC}, PC0, 9, 9, 0, 0, 0, 0);
        // R9: next slot killed even though it is a taken branch
        drive("R9", 1'b1, 1'b0, {6'h04, 5'd6, 5'd6, 16'h0004}, PC0, 1, 1, 0, 0, 0, 0);
        // R9: back to run
        drive("R9", 1'b1, 1'b0, {6'h00, 5'd6, 5'd6, 16'h0004}, PC0, 1, 2, 0, 0, 0, 0);
        // R6: forwarding on A makes operands equal
        drive("R6", 1'b1, 1'b0, {6'h04, 5'd2, 5'd3, 16'h0010}, 32'hFFFF_FFF0, 1, 2, 2, 0, 1, 0);
        // R9: kill held across stall
        drive("R9", 1'b1, 1'b1, {6'h05, 5'd2, 5'd3, 16'h0010}, PC0, 1, 2, 0, 0, 0, 0);
        drive("R9", 1'b1, 1'b1, {6'h05, 5'd2, 5'd3, 16'h0010}, PC0, 1, 2, 0, 0, 0, 0);
        drive("R9", 1'b1, 1'b0, {6'h05, 5'd2, 5'd3, 16'h0010}, PC0, 1, 2, 0, 0, 0, 0);
        // R6: forwarding on B breaks equality, BNE taken; R3 wrap
        drive("R6", 1'b1, 1'b0, {6'h05, 5'd2, 5'd3, 16'h4000}, 32'hFFFF_0000, 8, 8, 0, 3, 0, 1);
        drive("R9", 1'b1, 1'b0, {6'h2B, 5'd2, 5'd3, 16'h0000}, PC0, 0, 0, 0, 0, 0, 0);
        // R6: forwarding off ignores forwarded values
        drive("R6", 1'b1, 1'b0, {6'h04, 5'd2, 5'd3, 16'h0001}, PC0, 5, 6, 6, 6, 0, 0);
        drive("R7", 1'b1, 1'b0, {6'h00, 5'd0, 5'd0, 16'h0000}, PC0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule